// File: doc/BRIEF.md
# Multi-Format Signed Integer Adder

This block adds two N-bit operands that are read in one of three signed encodings: two's complement, one's complement or sign-and-magnitude. A two-bit format input chooses the encoding. The result is an N-bit sum in that same encoding, plus an overflow flag that is raised when the true sum cannot be represented.

The block is purely combinational and has no clock or reset. Three dedicated datapaths run in parallel on the same operands, and the format input selects one result. Two's complement uses one plain addition. One's complement folds the carry out of the top bit back into bit 0. Sign-and-magnitude either adds the magnitudes or compares them and subtracts the smaller from the larger. Where an encoding has two forms of zero, a zero result always comes out as all-zero bits.

Top module: `msfa_adder`

## Requirements
- R1: The format input selects the encoding as follows: 2'b00 two's complement, 2'b01 one's complement, 2'b10 sign-and-magnitude. The value 2'b11 behaves exactly like 2'b00.
- R2: In two's complement the sum is (a + b) modulo 2^N.
- R3: In two's complement the overflow flag is 1 exactly when the carry into the top bit differs from the carry out of it, i.e. when the true sum lies outside [-2^(N-1), 2^(N-1)-1].
- R4: In one's complement a negative value is the bitwise inverse of its magnitude, and the carry out of the top bit is added back in at bit 0. With no overflow, the sum encodes a + b (for N=4, 1010 + 0111 gives 0010).
- R5: In one's complement the overflow flag is 1 exactly when both operands have the same sign bit and the result sign bit differs, i.e. when the true sum lies outside ±(2^(N-1)-1). On overflow the sum encodes the true sum moved by 2^N-1 toward zero.
- R6: In sign-and-magnitude the top bit is the sign (1 means negative) and the lower N-1 bits are the magnitude. With equal signs the magnitudes are added and the sign is kept. Overflow is flagged when that addition carries out of N-1 bits, and the magnitude then keeps its low N-1 bits.
- R7: In sign-and-magnitude with differing signs the smaller magnitude is subtracted from the larger, and the result takes the sign of the operand with the larger magnitude (5 + (-6) gives -1). Equal magnitudes give zero. This case never overflows.
- R8: In one's complement and sign-and-magnitude a zero result is always all-zero bits. The all-ones pattern (one's complement) and a set sign bit over a zero magnitude (sign-and-magnitude) never appear on the sum.
- R9: The outputs depend only on the present inputs, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| fmt_i | input | 2 | Encoding select |
| sum_o | output | N | Sum in the selected encoding |
| ovf_o | output | 1 | Result not representable |

## Verification
The assertions check several rules on every input change. Two's complement and one's complement overflow may only occur between operands of the same sign. Mixed-sign sign-and-magnitude additions never overflow. No negative-zero pattern ever reaches the sum. Adding positive zero in one's complement returns the other operand, normalised. The exact sum values, the wrap of an overflowed result, the sign choice when magnitudes differ and the equivalence of the reserved format can only be shown by the bench. It sweeps every operand pair for all four format codes at N=4 and compares each result with plain integer arithmetic.

// File: rtl/msfa_pkg.sv
package msfa_pkg;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'b00,
        FMT_ONES = 2'b01,
        FMT_SMAG = 2'b10,
        FMT_RSVD = 2'b11
    } fmt_e;

    // Reserved code folds onto two's complement
    function automatic fmt_e resolve_fmt(input logic [1:0] code);
        fmt_e f;
        f = fmt_e'(code);
        if (f == FMT_RSVD) f = FMT_TWOS;
        return f;
    endfunction

endpackage

// File: rtl/msfa_twos.sv
module msfa_twos #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_o
);
    logic [N:0] full;
    logic       carry_into_msb;

    always_comb begin
        full           = {1'b0, a_i} + {1'b0, b_i};
        carry_into_msb = a_i[N-1] ^ b_i[N-1] ^ full[N-1];
        sum_o          = full[N-1:0];
        ovf_o          = carry_into_msb ^ full[N];
    end
endmodule

// File: rtl/msfa_ones.sv
module msfa_ones #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_o
);
    logic [N:0]   full;
    logic [N-1:0] wrapped;

    always_comb begin
        full    = {1'b0, a_i} + {1'b0, b_i};
        // end-around carry; cannot carry again
        wrapped = full[N-1:0] + {{(N-1){1'b0}}, full[N]};
        ovf_o   = (a_i[N-1] == b_i[N-1]) && (wrapped[N-1] != a_i[N-1]);
        sum_o   = (&wrapped) ? '0 : wrapped;
    end
endmodule

// File: rtl/msfa_smag.sv
module msfa_smag #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_o
);
    localparam int MW = N - 1;

    logic          sa, sb, res_sign, a_ge;
    logic [MW-1:0] ma, mb, res_mag;
    logic [MW:0]   mag_add;

    always_comb begin
        sa       = a_i[N-1];
        sb       = b_i[N-1];
        ma       = a_i[MW-1:0];
        mb       = b_i[MW-1:0];
        mag_add  = {1'b0, ma} + {1'b0, mb};
        a_ge     = (ma >= mb);
        ovf_o    = 1'b0;
        if (sa == sb) begin
            res_mag  = mag_add[MW-1:0];
            res_sign = sa;
            ovf_o    = mag_add[MW];
        end else begin
            res_mag  = a_ge ? (ma - mb) : (mb - ma);
            res_sign = a_ge ? sa : sb;
        end
        if (res_mag == '0) res_sign = 1'b0;
        sum_o = {res_sign, res_mag};
    end
endmodule

// File: rtl/msfa_adder.sv
module msfa_adder
    import msfa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [1:0]   fmt_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_o
);
    logic [N-1:0] twos_sum, ones_sum, smag_sum;
    logic         twos_ovf, ones_ovf, smag_ovf;
    fmt_e         fmt;

    msfa_twos #(.N(N)) u_twos (.a_i(a_i), .b_i(b_i), .sum_o(twos_sum), .ovf_o(twos_ovf));
    msfa_ones #(.N(N)) u_ones (.a_i(a_i), .b_i(b_i), .sum_o(ones_sum), .ovf_o(ones_ovf));
    msfa_smag #(.N(N)) u_smag (.a_i(a_i), .b_i(b_i), .sum_o(smag_sum), .ovf_o(smag_ovf));

    always_comb begin
        fmt = resolve_fmt(fmt_i);
        unique case (fmt)
            FMT_ONES: begin sum_o = ones_sum; ovf_o = ones_ovf; end
            FMT_SMAG: begin sum_o = smag_sum; ovf_o = smag_ovf; end
            default:  begin sum_o = twos_sum; ovf_o = twos_ovf; end
        endcase
    end
endmodule

// File: rtl/msfa_adder_chk.sv
module msfa_adder_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [1:0]   fmt_i,
    input logic [N-1:0] sum_o,
    input logic         ovf_o
);
    logic [N-1:0] smag_negzero;
    always_comb smag_negzero = {1'b1, {(N-1){1'b0}}};

    always_comb begin
        // R3
        twos_ovf_sign_chk: assert (!((fmt_i == 2'b00 || fmt_i == 2'b11) && ovf_o) ||
                                   (a_i[N-1] == b_i[N-1] && sum_o[N-1] != a_i[N-1]))
            else $error("two's complement overflow without sign mismatch");
        // R5
        ones_ovf_sign_chk: assert (!(fmt_i == 2'b01 && ovf_o) || (a_i[N-1] == b_i[N-1]))
            else $error("one's complement overflow on mixed signs");
        // R7
        smag_mixed_no_ovf_chk: assert (!(fmt_i == 2'b10 && a_i[N-1] != b_i[N-1]) || !ovf_o)
            else $error("sign-magnitude overflow on mixed signs");
        // R8
        ones_no_negzero_chk: assert (!(fmt_i == 2'b01) || !(&sum_o))
            else $error("one's complement negative zero on sum");
        // R8
        smag_no_negzero_chk: assert (!(fmt_i == 2'b10) || sum_o != smag_negzero)
            else $error("sign-magnitude negative zero on sum");
        // R4
        ones_plus_zero_chk: assert (!(fmt_i == 2'b01 && a_i == '0) ||
                                    (!ovf_o && sum_o == ((&b_i) ? '0 : b_i)))
            else $error("one's complement +0 identity broken");
    end
endmodule

bind msfa_adder msfa_adder_chk #(.N(N)) u_chk (
    .a_i(a_i), .b_i(b_i), .fmt_i(fmt_i), .sum_o(sum_o), .ovf_o(ovf_o)
);

// File: tb/sim_msfa_adder.sv
`timescale 1ns/1ps
module sim_msfa_adder;
    localparam int N    = 4;
    localparam int HALF = 1 << (N - 1);
    localparam int FULL = 1 << N;

    logic         clk = 1'b0;
    logic [N-1:0] a, b;
    logic [1:0]   fmt;
    logic [N-1:0] sum;
    logic         ovf;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msfa_adder #(.N(N)) u0 (.a_i(a), .b_i(b), .fmt_i(fmt), .sum_o(sum), .ovf_o(ovf));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s fmt=%0d a=%0h b=%0h actual=%0h expected=%0h",
                     req, fmt, a, b, act, exp);
        end
    endtask

    function automatic int decode(input int f, input int x);
        if (f == 1) return (x >= HALF) ? -((~x) & (FULL - 1)) : x;
        if (f == 2) return (x >= HALF) ? -(x - HALF) : x;
        return (x >= HALF) ? x - FULL : x;
    endfunction

    task automatic expect_of(input int f, input int x, input int y,
                             output int pat, output bit o);
        int s, w, m;
        s = decode(f, x) + decode(f, y);
        if (f == 1) begin
            o = (s > HALF - 1) || (s < -(HALF - 1));
            w = (s > HALF - 1) ? s - (FULL - 1) : (s < -(HALF - 1)) ? s + (FULL - 1) : s;
            pat = (w < 0) ? ((~(-w)) & (FULL - 1)) : w;
        end else if (f == 2) begin
            o = (s > HALF - 1) || (s < -(HALF - 1));
            m = ((s < 0) ? -s : s) % HALF;
            pat = (m == 0) ? 0 : ((s < 0) ? (HALF | m) : m);
        end else begin
            o = (s > HALF - 1) || (s < -HALF);
            pat = s & (FULL - 1);
        end
    endtask

    initial begin
        int ep;
        bit eo;
        a = '0; b = '0; fmt = 2'b00;
        @(negedge clk); #1;
        check(sum == 0 && ovf == 0, "R2 zero inputs", {sum, ovf}, 0);
        // fixed examples
        @(negedge clk); fmt = 2'b01; a = 4'b1010; b = 4'b0111; #1;
        check(sum == 4'b0010 && !ovf, "R4 -5+7", sum, 4'b0010);
        @(negedge clk); fmt = 2'b10; a = 4'b0101; b = 4'b1110; #1;
        check(sum == 4'b1001 && !ovf, "R7 5+(-6)", sum, 4'b1001);
        // R9: inputs change mid-cycle, output follows with no clock edge
        @(posedge clk); #1; fmt = 2'b00; a = 4'b0110; b = 4'b0001; #1;
        check(sum == 4'b0111 && clk == 1'b1, "R9 no-edge update", sum, 4'b0111);
        // exhaustive sweep
        for (int f = 0; f < 4; f++) begin
            for (int x = 0; x < FULL; x++) begin
                for (int y = 0; y < FULL; y++) begin
                    @(negedge clk);
                    fmt = f[1:0]; a = x[N-1:0]; b = y[N-1:0];
                    #1;
                    expect_of((f == 3) ? 0 : f, x, y, ep, eo);
                    if (f == 3) begin
                        check(sum == ep[N-1:0] && ovf == eo, "R1 reserved code", {sum, ovf}, {ep[N-1:0], eo});
                    end else if (f == 0) begin
                        check(sum == ep[N-1:0], "R2 two's sum", sum, ep);
                        check(ovf == eo, "R3 two's overflow", ovf, eo);
                    end else if (f == 1) begin
                        check(sum == ep[N-1:0], eo ? "R5 one's wrap" : "R4 one's sum", sum, ep);
                        check(ovf == eo, "R5 one's overflow", ovf, eo);
                        if (ep == 0) check(sum == 0, "R8 one's zero", sum, 0);
                    end else begin
                        if (x[N-1] == y[N-1]) begin
                            check(sum == ep[N-1:0], "R6 smag same-sign sum", sum, ep);
                            check(ovf == eo, "R6 smag overflow", ovf, eo);
                        end else begin
                            check(sum == ep[N-1:0], "R7 smag mixed sum", sum, ep);
                            check(ovf == 1'b0, "R7 smag mixed overflow", ovf, 0);
                        end
                        if (ep == 0) check(sum == 0, "R8 smag zero", sum, 0);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule